// File: doc/BRIEF.md
# Processor exception entry sequencer

This block carries out the hardware side of entering a software exception on a small 32-bit CPU. Five single-cycle fault requests can start an entry: two memory faults (unmapped access, unaligned access) and three floating-point faults (FP instruction with the FP unit disabled, unimplemented FP instruction, enabled FP arithmetic trap). One accepted request starts a fixed sequence on a byte-addressed, little-endian memory write port. The PC is pushed as a word, then the status word as a halfword. On boards configured for it, a system-error flag byte is then written into the memory-mapped interrupt controller. Finally the sequencer masks interrupts, moves the stack pointer down by the eight-byte frame and redirects the PC to the single handler vector.

The block owns the PC, SP and status-word registers it updates and shows them on its outputs. The CPU loads them through a plain load strobe while the sequencer is idle. The memory write port is a valid/ready stream. The block raises `mem_valid` with a stable command and keeps it stable until the memory accepts it with `mem_ready` high at a clock edge. The memory may hold `mem_ready` low for any number of cycles to apply back-pressure. No write is lost or repeated, and the order of writes is fixed. A request that arrives while a sequence is running pushes no second frame. It raises an error pulse instead.

Top module: `exc_entry_seq`

## Requirements
- R1: The first write of a sequence stores the PC as a word at address SP-4: `mem_size`=2, `mem_be`=4'b1111, `mem_wdata`=PC (byte lane 0 holds the least significant byte).
- R2: The second write stores the status word as a halfword at SP-8: `mem_size`=1. The lane mask is 4'b0011 when bit 1 of the address is 0 and 4'b1100 when it is 1. `mem_wdata` carries the halfword in both halves.
- R3: When `board_en` is high in the accepting cycle, a third write stores byte 0x04 at address 0x34000103: `mem_size`=0, `mem_be`=4'b1000, `mem_wdata`=32'h04040404. When `board_en` is low, only two writes occur.
- R4: After the last write, in one cycle, status bit 11 (interrupt enable) is cleared and all other status bits are kept. SP drops by 8, and PC becomes 32'h40000008.
- R5: `busy` is high from the cycle after acceptance through the update cycle. `done` is a single-cycle pulse in the cycle after the update, with `busy` low.
- R6: A request seen while `busy` is high starts nothing and writes nothing. `err_reentry` pulses high for one cycle in the following cycle.
- R7: `cause` takes the code of the accepted fault and holds it until the next acceptance: FP-disabled 0x1c0, FP-unimplemented 0x1c8, FP-arithmetic 0x1d0, unmapped 0x1e0, unaligned 0x1e8.
- R8: For simultaneous requests, the priority order is unmapped, then unaligned, then FP-disabled, then FP-unimplemented, then FP-arithmetic.
- R9: While `mem_valid` is high and `mem_ready` is low, the address, size, lane mask and data hold. Each write is issued exactly once and in order under any back-pressure.
- R10: `arch_wr_en` loads PC, SP and status from `arch_*_in` only when the block is idle. A load is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `mem_valid` and `err_reentry` are low, and PC, SP, status and `cause` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_unmapped | input | 1 | Unmapped memory access fault |
| req_unaligned | input | 1 | Unaligned memory access fault |
| req_fp_off | input | 1 | FP instruction while FP unit disabled |
| req_fp_unimp | input | 1 | Unimplemented FP instruction |
| req_fp_arith | input | 1 | Enabled FP arithmetic exception |
| board_en | input | 1 | Board option: also write the system-error flag |
| arch_wr_en | input | 1 | Load strobe for PC/SP/status |
| arch_pc_in | input | 32 | PC load value |
| arch_sp_in | input | 32 | SP load value |
| arch_psw_in | input | 16 | Status-word load value |
| mem_valid | output | 1 | Write command valid |
| mem_ready | input | 1 | Memory accepts the command |
| mem_addr | output | 32 | Byte address of the write |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| pc_o | output | 32 | Current PC |
| sp_o | output | 32 | Current SP |
| psw_o | output | 16 | Current status word |
| cause | output | 12 | Code of the last accepted fault |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_reentry | output | 1 | Request rejected during a sequence |

## Verification
The bench covers requests that land in the middle of a stalled sequence. A design without a working guard would push a second frame and end with SP down by 16, or take the later cause code. It also checks loads of PC/SP issued during a sequence, which a careless design would let corrupt the frame or the final SP. Stuttering back-pressure is applied to catch a write that is skipped, repeated or reordered. Mixed simultaneous requests catch a reversed priority. The board flag is tried both on and off, and a wrong lane mask or a missing third write shows up in the captured write log.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH_PC = 3'd1,
    ST_PUSH_PSW = 3'd2,
    ST_SYS_FLAG = 3'd3,
    ST_UPDATE = 3'd4
  } seq_st_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_t;

  localparam int NUM_SRC = 5;
  localparam int SRC_UNMAPPED = 0;
  localparam int SRC_UNALIGNED = 1;
  localparam int SRC_FP_OFF = 2;
  localparam int SRC_FP_UNIMP = 3;
  localparam int SRC_FP_ARITH = 4;

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb #(
  parameter int NSRC = 5,
  parameter int CODE_W = 12,
  parameter logic [NSRC*CODE_W-1:0] CODES = '0
) (
  input  logic [NSRC-1:0]   req,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  // Index 0 has the highest priority: scan downward so the lowest set index wins.
  always_comb begin
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = CODES[i*CODE_W +: CODE_W];
    end
  end

  assign any = |req;

endmodule

// File: rtl/exc_lane_fmt.sv
module exc_lane_fmt
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   addr,
  input  acc_size_t         size,
  input  logic [XLEN-1:0]   value,
  output logic [XLEN/8-1:0] be,
  output logic [XLEN-1:0]   wdata
);
  localparam int LANES = XLEN / 8;
  localparam int LANE_AW = $clog2(LANES);

  logic [LANE_AW-1:0] lane;
  assign lane = addr[LANE_AW-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        be = {{(LANES-1){1'b0}}, 1'b1} << lane;
        wdata = {LANES{value[7:0]}};
      end
      SZ_HALF: begin
        be = {{(LANES-2){1'b0}}, 2'b11} << {lane[LANE_AW-1:1], 1'b0};
        wdata = {(LANES/2){value[15:0]}};
      end
      default: begin
        be = '1;
        wdata = value;
      end
    endcase
  end

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    flag_en,
  input  logic    mem_ready,
  output seq_st_t state,
  output logic    mem_valid,
  output logic    upd,
  output logic    done
);
  seq_st_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (start) nxt = ST_PUSH_PC;
      ST_PUSH_PC:  if (mem_ready) nxt = ST_PUSH_PSW;
      ST_PUSH_PSW: if (mem_ready) nxt = flag_en ? ST_SYS_FLAG : ST_UPDATE;
      ST_SYS_FLAG: if (mem_ready) nxt = ST_UPDATE;
      ST_UPDATE:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done <= 1'b0;
    end else begin
      state <= nxt;
      done <= (state == ST_UPDATE);
    end
  end

  assign mem_valid = (state == ST_PUSH_PC) || (state == ST_PUSH_PSW) ||
                     (state == ST_SYS_FLAG);
  assign upd = (state == ST_UPDATE);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PSW_W = 16,
  parameter int IE_BIT = 11,
  parameter int CODE_W = 12,
  parameter int FRAME_BYTES = 8,
  parameter logic [31:0] VECTOR = 32'h4000_0008,
  parameter logic [31:0] FLAG_ADDR = 32'h3400_0103,
  parameter logic [7:0] FLAG_BYTE = 8'h04,
  parameter logic [11:0] C_FP_OFF = 12'h1c0,
  parameter logic [11:0] C_FP_UNIMP = 12'h1c8,
  parameter logic [11:0] C_FP_ARITH = 12'h1d0,
  parameter logic [11:0] C_UNMAPPED = 12'h1e0,
  parameter logic [11:0] C_UNALIGNED = 12'h1e8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_unmapped,
  input  logic              req_unaligned,
  input  logic              req_fp_off,
  input  logic              req_fp_unimp,
  input  logic              req_fp_arith,
  input  logic              board_en,
  input  logic              arch_wr_en,
  input  logic [XLEN-1:0]   arch_pc_in,
  input  logic [XLEN-1:0]   arch_sp_in,
  input  logic [PSW_W-1:0]  arch_psw_in,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic [1:0]        mem_size,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sp_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic [CODE_W-1:0] cause,
  output logic              busy,
  output logic              done,
  output logic              err_reentry
);
  localparam int SLOT_BYTES = FRAME_BYTES / 2;
  localparam logic [XLEN-1:0] SLOT_OFS = XLEN'(SLOT_BYTES);
  localparam logic [XLEN-1:0] FRAME_OFS = XLEN'(FRAME_BYTES);
  localparam logic [NUM_SRC*CODE_W-1:0] CODE_TABLE = {
    CODE_W'(C_FP_ARITH), CODE_W'(C_FP_UNIMP), CODE_W'(C_FP_OFF),
    CODE_W'(C_UNALIGNED), CODE_W'(C_UNMAPPED)
  };

  logic [NUM_SRC-1:0] req_vec;
  logic any_req, accept, flag_q, upd;
  logic [CODE_W-1:0] win_code;
  seq_st_t state;
  acc_size_t cmd_size;
  logic [XLEN-1:0] cmd_addr, cmd_val;
  logic [XLEN-1:0] pc_q, sp_q;
  logic [PSW_W-1:0] psw_q;

  assign req_vec[SRC_UNMAPPED] = req_unmapped;
  assign req_vec[SRC_UNALIGNED] = req_unaligned;
  assign req_vec[SRC_FP_OFF] = req_fp_off;
  assign req_vec[SRC_FP_UNIMP] = req_fp_unimp;
  assign req_vec[SRC_FP_ARITH] = req_fp_arith;

  exc_cause_arb #(.NSRC(NUM_SRC), .CODE_W(CODE_W), .CODES(CODE_TABLE)) arb_i (
    .req(req_vec), .any(any_req), .code(win_code)
  );

  assign busy = (state != ST_IDLE);
  assign accept = any_req && !busy;

  exc_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .flag_en(flag_q),
    .mem_ready(mem_ready), .state(state), .mem_valid(mem_valid),
    .upd(upd), .done(done)
  );

  // Control capture and the rejection pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      flag_q <= 1'b0;
      err_reentry <= 1'b0;
    end else begin
      err_reentry <= any_req && busy;
      if (accept) begin
        cause <= win_code;
        flag_q <= board_en;
      end
    end
  end

  // Architectural state: sequence update has priority, loads only when idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
      psw_q <= '0;
    end else if (upd) begin
      pc_q <= XLEN'(VECTOR);
      sp_q <= sp_q - FRAME_OFS;
      psw_q[IE_BIT] <= 1'b0;
    end else if (arch_wr_en && !busy && !accept) begin
      pc_q <= arch_pc_in;
      sp_q <= arch_sp_in;
      psw_q <= arch_psw_in;
    end
  end

  // Write command for the current step of the sequence.
  always_comb begin
    cmd_addr = sp_q - SLOT_OFS;
    cmd_size = SZ_WORD;
    cmd_val = pc_q;
    unique case (state)
      ST_PUSH_PSW: begin
        cmd_addr = sp_q - FRAME_OFS;
        cmd_size = SZ_HALF;
        cmd_val = XLEN'(psw_q);
      end
      ST_SYS_FLAG: begin
        cmd_addr = XLEN'(FLAG_ADDR);
        cmd_size = SZ_BYTE;
        cmd_val = XLEN'(FLAG_BYTE);
      end
      default: ;
    endcase
  end

  exc_lane_fmt #(.XLEN(XLEN)) fmt_i (
    .addr(cmd_addr), .size(cmd_size), .value(cmd_val),
    .be(mem_be), .wdata(mem_wdata)
  );

  assign mem_addr = cmd_addr;
  assign mem_size = cmd_size;
  assign pc_o = pc_q;
  assign sp_o = sp_q;
  assign psw_o = psw_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 32,
  parameter int PSW_W = 16,
  parameter int IE_BIT = 11,
  parameter logic [31:0] VECTOR = 32'h4000_0008
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_req,
  input logic              busy,
  input logic              done,
  input logic              err_reentry,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN/8-1:0] mem_be,
  input logic [XLEN-1:0]   mem_wdata,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   sp_o,
  input logic [PSW_W-1:0]  psw_o
);
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
    $stable(mem_be) && $stable(mem_wdata));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_valid);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  vector_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pc_o == XLEN'(VECTOR) && !psw_o[IE_BIT]);

  // R4
  frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sp_o == $past(sp_o) - XLEN'(8));

  // R6
  reentry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && any_req |=> err_reentry);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .XLEN(XLEN), .PSW_W(PSW_W), .IE_BIT(IE_BIT), .VECTOR(VECTOR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .any_req(any_req), .busy(busy), .done(done),
  .err_reentry(err_reentry), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .pc_o(pc_o), .sp_o(sp_o), .psw_o(psw_o)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h4000_0008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_unmapped = 0, req_unaligned = 0, req_fp_off = 0, req_fp_unimp = 0, req_fp_arith = 0;
  logic board_en = 0, arch_wr_en = 0;
  logic [31:0] arch_pc_in = 0, arch_sp_in = 0;
  logic [15:0] arch_psw_in = 0;
  logic mem_valid, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, pc_o, sp_o;
  logic [1:0] mem_size;
  logic [3:0] mem_be;
  logic [15:0] psw_o;
  logic [11:0] cause;
  logic busy, done, err_reentry;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_unmapped(req_unmapped), .req_unaligned(req_unaligned),
    .req_fp_off(req_fp_off), .req_fp_unimp(req_fp_unimp), .req_fp_arith(req_fp_arith),
    .board_en(board_en), .arch_wr_en(arch_wr_en), .arch_pc_in(arch_pc_in),
    .arch_sp_in(arch_sp_in), .arch_psw_in(arch_psw_in), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_size(mem_size), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .pc_o(pc_o), .sp_o(sp_o), .psw_o(psw_o), .cause(cause),
    .busy(busy), .done(done), .err_reentry(err_reentry)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit stall = 0;
  int stall_cnt = 0;

  // Memory model: ready pattern, and a log of accepted writes.
  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    mem_ready <= stall ? ((stall_cnt % 3) == 2) : 1'b1;
  end

  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [1:0]  lg_size [64];
  logic [3:0]  lg_be   [64];
  int lg_n = 0;
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      lg_addr[lg_n[5:0]] <= mem_addr;
      lg_data[lg_n[5:0]] <= mem_wdata;
      lg_size[lg_n[5:0]] <= mem_size;
      lg_be[lg_n[5:0]] <= mem_be;
      lg_n <= lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_arch(input logic [31:0] pc, input logic [31:0] sp, input logic [15:0] psw);
    @(negedge clk);
    arch_wr_en = 1; arch_pc_in = pc; arch_sp_in = sp; arch_psw_in = psw;
    @(negedge clk);
    arch_wr_en = 0;
  endtask

  // rq bits: 0 unmapped, 1 unaligned, 2 fp_off, 3 fp_unimp, 4 fp_arith
  task automatic fire(input logic [4:0] rq, input bit brd);
    @(negedge clk);
    {req_fp_arith, req_fp_unimp, req_fp_off, req_unaligned, req_unmapped} = rq;
    board_en = brd;
    @(negedge clk);
    {req_fp_arith, req_fp_unimp, req_fp_off, req_unaligned, req_unmapped} = '0;
    board_en = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R5 done pulse seen", {31'd0, done}, 32'd1);
  endtask

  task automatic check_frame(input int base, input bit brd, input logic [31:0] pc0,
                             input logic [31:0] sp0, input logic [15:0] psw0,
                             input logic [11:0] code, input string tag);
    chk(lg_n - base == (brd ? 3 : 2), {tag, " R3 write count"}, lg_n - base, brd ? 3 : 2);
    chk(lg_addr[base[5:0]] == sp0 - 4 && lg_size[base[5:0]] == 2 && lg_be[base[5:0]] == 4'hF,
        {tag, " R1 pc slot addr/size/be"}, lg_addr[base[5:0]], sp0 - 4);
    chk(lg_data[base[5:0]] == pc0, {tag, " R1 pc slot data"}, lg_data[base[5:0]], pc0);
    chk(lg_addr[base[5:0]+1] == sp0 - 8 && lg_size[base[5:0]+1] == 1 && lg_be[base[5:0]+1] == 4'h3,
        {tag, " R2 psw slot addr/size/be"}, lg_addr[base[5:0]+1], sp0 - 8);
    chk(lg_data[base[5:0]+1] == {psw0, psw0}, {tag, " R2 psw slot data"},
        lg_data[base[5:0]+1], {psw0, psw0});
    if (brd) begin
      chk(lg_addr[base[5:0]+2] == 32'h3400_0103 && lg_size[base[5:0]+2] == 0 &&
          lg_be[base[5:0]+2] == 4'h8, {tag, " R3 flag addr/size/be"},
          lg_addr[base[5:0]+2], 32'h3400_0103);
      chk(lg_data[base[5:0]+2] == 32'h0404_0404, {tag, " R3 flag data"},
          lg_data[base[5:0]+2], 32'h0404_0404);
    end
    chk(pc_o == VEC, {tag, " R4 pc vector"}, pc_o, VEC);
    chk(sp_o == sp0 - 8, {tag, " R4 sp drop"}, sp_o, sp0 - 8);
    chk(psw_o == (psw0 & 16'hF7FF), {tag, " R4 psw ie clear"}, {16'd0, psw_o}, {16'd0, psw0 & 16'hF7FF});
    chk(cause == code, {tag, " R7 cause"}, {20'd0, cause}, {20'd0, code});
    chk(busy == 0, {tag, " R5 busy low at done"}, {31'd0, busy}, 0);
    @(negedge clk);
    chk(done == 0, {tag, " R5 done single cycle"}, {31'd0, done}, 0);
  endtask

  task automatic run_seq(input logic [4:0] rq, input bit brd, input logic [11:0] code,
                         input logic [31:0] pc0, input logic [31:0] sp0,
                         input logic [15:0] psw0, input string tag);
    int base;
    load_arch(pc0, sp0, psw0);
    base = lg_n;
    fire(rq, brd);
    chk(busy == 1, {tag, " R5 busy after accept"}, {31'd0, busy}, 1);
    wait_done();
    check_frame(base, brd, pc0, sp0, psw0, code, tag);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && mem_valid == 0 && err_reentry == 0, "R11 reset controls",
        {busy, done, mem_valid, err_reentry}, 0);
    chk(pc_o == 0 && sp_o == 0 && psw_o == 0 && cause == 0, "R11 reset state", pc_o ^ sp_o, 0);
  endtask

  task automatic t_basic();
    run_seq(5'b00001, 0, 12'h1e0, 32'h0000_1234, 32'h0008_0000, 16'h0F35, "basic");
  endtask

  task automatic t_board();
    run_seq(5'b00100, 1, 12'h1c0, 32'hDEAD_BEE0, 32'h0010_0040, 16'h0800, "board");
  endtask

  task automatic t_fp_codes();
    run_seq(5'b01000, 0, 12'h1c8, 32'h0000_2000, 32'h0000_8000, 16'hFFFF, "R7 unimp");
    run_seq(5'b10000, 0, 12'h1d0, 32'h0000_3000, 32'h0000_9000, 16'h0001, "R7 arith");
    run_seq(5'b00010, 0, 12'h1e8, 32'h0000_3004, 32'h0000_9100, 16'h0002, "R7 unaligned");
  endtask

  task automatic t_priority();
    run_seq(5'b11111, 0, 12'h1e0, 32'h10, 32'h1000, 16'h0800, "R8 all");
    run_seq(5'b11110, 0, 12'h1e8, 32'h20, 32'h2000, 16'h0800, "R8 unaligned first");
    run_seq(5'b11100, 0, 12'h1c0, 32'h30, 32'h3000, 16'h0800, "R8 fp_off first");
    run_seq(5'b11000, 0, 12'h1c8, 32'h40, 32'h4000, 16'h0800, "R8 unimp first");
  endtask

  task automatic t_backpressure();
    stall = 1;
    run_seq(5'b00001, 1, 12'h1e0, 32'hCAFE_0000, 32'h0002_0000, 16'h0A5A, "R9 stalled");
    stall = 0;
  endtask

  task automatic t_reentry();
    int base;
    logic [31:0] pc0 = 32'h0000_7770, sp0 = 32'h0004_0000;
    logic [15:0] psw0 = 16'h0880;
    load_arch(pc0, sp0, psw0);
    stall = 1;
    base = lg_n;
    fire(5'b10000, 0);
    chk(busy == 1, "R6 busy before second request", {31'd0, busy}, 1);
    @(negedge clk);
    req_unmapped = 1; arch_wr_en = 1;
    arch_pc_in = 32'h1111_1111; arch_sp_in = 32'h2222_2220; arch_psw_in = 16'h3333;
    @(negedge clk);
    req_unmapped = 0; arch_wr_en = 0;
    chk(err_reentry == 1, "R6 err pulse", {31'd0, err_reentry}, 1);
    @(negedge clk);
    chk(err_reentry == 0, "R6 err single cycle", {31'd0, err_reentry}, 0);
    wait_done();
    check_frame(base, 0, pc0, sp0, psw0, 12'h1d0, "R6 R10 reentry");
    stall = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_board();
    t_fp_codes();
    t_priority();
    t_backpressure();
    t_reentry();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule